// File: doc/BRIEF.md
# Eight-Bank Chip-Select Memory Controller

This block sits between a simple internal bus and a set of external static memories. Each request carries an address, a read or write flag and four byte enables. The block compares the address against eight programmable banks and turns it into one chip select, one output enable for reads or byte-lane write enables for writes. It holds those strobes for a programmable number of wait states and then pulses a ready response. A request that finds no bank, or that writes to a protected bank, gets an error response one cycle later and drives no strobe.

Each bank is programmed through a small register port. A bank has a valid bit, a base address, a block-size code, a wait-state count, a port-width code and a write-protect bit. The bank at index 0 is the boot bank. It leaves reset valid, covering the lowest 256 MB, with the longest wait count and a port width taken from a strap input. The other banks leave reset invalid. The selected bank's port-width code is shown on an output while its strobes are active, so the surrounding logic can steer the data lanes.

Top module: `memctl_cs`

## Requirements
- R1: During reset and after it, no strobe or response is active. Bank 0 is valid with base 0, size code 13, 30 wait states, no write protection and width equal to the strap `boot_width`. Banks 1 to 7 are invalid.
- R2: A valid bank matches when (addr & M) == (base & M). M has all bits set except the low 15+size bits, so size codes 0..13 give blocks of 32 KB up to 256 MB. A size code above 13 is stored as 13.
- R3: When several valid banks match, the lowest-numbered one is selected.
- R4: A request that matches no valid bank gives `rsp_ready` and `rsp_err` together in the cycle after the request. No chip select, write enable or output enable is asserted for it.
- R5: An accepted access asserts exactly one chip select, bit n for bank n. It holds that chip select for 1 + wait cycles, starting in the cycle after the request. `rsp_ready` pulses with `rsp_err` low in the cycle after the last strobe cycle.
- R6: During a read access `mem_oe` is 1 and `mem_we` is 0. During a write access `mem_oe` is 0 and `mem_we` equals the request's byte enables.
- R7: A write to a bank with write protection set asserts no strobe and gives `rsp_ready` with `rsp_err` in the next cycle. A read of the same bank completes normally.
- R8: A programmed wait count above 30 is stored as 30, so no access holds its strobes longer than 31 cycles.
- R9: While strobes are active, `mem_width` shows the selected bank's width code (0 = 32-bit, 1 = 8-bit, 2 = 16-bit). It is 0 otherwise.
- R10: A register write takes effect for requests made in later cycles. A request made in the same cycle as a register write is decoded with the bank settings in force before that write.
- R11: `req_valid` is ignored while an access is in progress. Such a request produces no later response and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_width | input | 2 | Strap giving bank 0's width code at reset |
| cfg_we | input | 1 | Register-port write strobe |
| cfg_sel | input | 3 | Bank index to write |
| cfg_valid | input | 1 | Bank valid bit |
| cfg_base | input | 32 | Bank base address |
| cfg_size | input | 4 | Block-size code |
| cfg_wait | input | 5 | Wait-state count |
| cfg_width | input | 2 | Port-width code |
| cfg_wp | input | 1 | Write-protect bit |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Request address |
| req_be | input | 4 | Request byte enables |
| rsp_ready | output | 1 | Completion pulse |
| rsp_err | output | 1 | Error qualifier for `rsp_ready` |
| mem_cs | output | 8 | Per-bank chip selects, active high |
| mem_oe | output | 1 | Output enable, active high |
| mem_we | output | 4 | Byte-lane write enables, active high |
| mem_width | output | 2 | Width code of the selected bank |

## Verification
Two functions can meet in one clock edge: a register write and the decoding of a new request. The bench drives a register write to bank 1 that changes its wait count from 2 to 7, in the same cycle as a request to that bank. It expects 3 strobe cycles for that request and 8 strobe cycles for the next one. Near-exhaustive sweeps then cover every wait count from 0 to 31 and every size code at both edges of the block, and each length and hit/miss result is computed arithmetically in the bench.

// File: rtl/memctl_pkg.sv
package memctl_pkg;
    localparam int ADDR_W = 32;
    localparam int WAIT_W = 5;
    localparam int SIZE_W = 4;
    localparam int PW_W   = 2;
    localparam int LANES  = 4;

    typedef enum logic [PW_W-1:0] {
        PW_32 = 2'd0,
        PW_8  = 2'd1,
        PW_16 = 2'd2
    } port_width_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] base;
        logic [SIZE_W-1:0] size;
        logic [WAIT_W-1:0] wait_n;
        logic [PW_W-1:0]   width;
        logic              wprot;
    } bank_cfg_t;
endpackage

// File: rtl/memctl_bank_regs.sv
module memctl_bank_regs
    import memctl_pkg::*;
#(
    parameter int NUM_BANKS    = 8,
    parameter int MAX_WAIT     = 30,
    parameter int SIZE_MAX     = 13,
    parameter int BOOT_WAIT    = 30,
    localparam int SEL_W       = $clog2(NUM_BANKS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [PW_W-1:0]              boot_width,
    input  logic                         cfg_we,
    input  logic [SEL_W-1:0]             cfg_sel,
    input  logic                         cfg_valid,
    input  logic [ADDR_W-1:0]            cfg_base,
    input  logic [SIZE_W-1:0]            cfg_size,
    input  logic [WAIT_W-1:0]            cfg_wait,
    input  logic [PW_W-1:0]              cfg_width,
    input  logic                         cfg_wp,
    output bank_cfg_t [NUM_BANKS-1:0]    banks
);
    bank_cfg_t [NUM_BANKS-1:0] regs_d, regs_q, regs_rst;
    bank_cfg_t                 wr_val;

    always_comb begin
        // clamp out-of-range fields on the way in
        wr_val.valid  = cfg_valid;
        wr_val.base   = cfg_base;
        wr_val.size   = (32'(cfg_size) > SIZE_MAX) ? SIZE_W'(SIZE_MAX) : cfg_size;
        wr_val.wait_n = (32'(cfg_wait) > MAX_WAIT) ? WAIT_W'(MAX_WAIT) : cfg_wait;
        wr_val.width  = cfg_width;
        wr_val.wprot  = cfg_wp;

        regs_rst = '0;
        regs_rst[0].valid  = 1'b1;
        regs_rst[0].size   = SIZE_W'(SIZE_MAX);
        regs_rst[0].wait_n = WAIT_W'(BOOT_WAIT);
        regs_rst[0].width  = boot_width;

        regs_d = regs_q;
        if (cfg_we) regs_d[cfg_sel] = wr_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= regs_rst;
        else        regs_q <= regs_d;
    end

    assign banks = regs_q;
endmodule

// File: rtl/memctl_decode.sv
module memctl_decode
    import memctl_pkg::*;
#(
    parameter int NUM_BANKS    = 8,
    parameter int MIN_BLK_LOG2 = 15,
    localparam int SEL_W       = $clog2(NUM_BANKS)
) (
    input  bank_cfg_t [NUM_BANKS-1:0] banks,
    input  logic [ADDR_W-1:0]         addr,
    output logic                      hit,
    output logic [SEL_W-1:0]          sel
);
    logic [NUM_BANKS-1:0] match;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cmp
        logic [ADDR_W-1:0] mask;
        always_comb begin
            mask     = {ADDR_W{1'b1}} << (MIN_BLK_LOG2 + int'(banks[g].size));
            match[g] = banks[g].valid && ((addr & mask) == (banks[g].base & mask));
        end
    end

    // lowest index wins: scan downwards so the last assignment is the lowest
    always_comb begin
        hit = |match;
        sel = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (match[i]) sel = SEL_W'(i);
        end
    end
endmodule

// File: rtl/memctl_cs.sv
module memctl_cs
    import memctl_pkg::*;
#(
    parameter int NUM_BANKS    = 8,
    parameter int MAX_WAIT     = 30,
    parameter int MIN_BLK_LOG2 = 15,
    parameter int MAX_BLK_LOG2 = 28,
    parameter int BOOT_WAIT    = 30,
    localparam int SEL_W       = $clog2(NUM_BANKS),
    localparam int SIZE_MAX    = MAX_BLK_LOG2 - MIN_BLK_LOG2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           boot_width,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic                 cfg_valid,
    input  logic [31:0]          cfg_base,
    input  logic [3:0]           cfg_size,
    input  logic [4:0]           cfg_wait,
    input  logic [1:0]           cfg_width,
    input  logic                 cfg_wp,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [31:0]          req_addr,
    input  logic [3:0]           req_be,
    output logic                 rsp_ready,
    output logic                 rsp_err,
    output logic [NUM_BANKS-1:0] mem_cs,
    output logic                 mem_oe,
    output logic [3:0]           mem_we,
    output logic [1:0]           mem_width
);
    typedef struct packed {
        logic                 busy;
        logic [NUM_BANKS-1:0] cs;
        logic                 oe;
        logic [LANES-1:0]     we;
        logic [PW_W-1:0]      width;
        logic [WAIT_W-1:0]    cnt;
        logic                 rdy;
        logic                 err;
    } acc_t;

    bank_cfg_t [NUM_BANKS-1:0] banks;
    logic                      hit;
    logic [SEL_W-1:0]          hit_sel;
    acc_t                      acc_d, acc_q;

    memctl_bank_regs #(
        .NUM_BANKS (NUM_BANKS),
        .MAX_WAIT  (MAX_WAIT),
        .SIZE_MAX  (SIZE_MAX),
        .BOOT_WAIT (BOOT_WAIT)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_width (boot_width),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_valid  (cfg_valid),
        .cfg_base   (cfg_base),
        .cfg_size   (cfg_size),
        .cfg_wait   (cfg_wait),
        .cfg_width  (cfg_width),
        .cfg_wp     (cfg_wp),
        .banks      (banks)
    );

    memctl_decode #(
        .NUM_BANKS    (NUM_BANKS),
        .MIN_BLK_LOG2 (MIN_BLK_LOG2)
    ) u_dec (
        .banks (banks),
        .addr  (req_addr),
        .hit   (hit),
        .sel   (hit_sel)
    );

    always_comb begin
        acc_d     = acc_q;
        acc_d.rdy = 1'b0;
        acc_d.err = 1'b0;
        if (!acc_q.busy) begin
            if (req_valid) begin
                if (!hit || (req_write && banks[hit_sel].wprot)) begin
                    acc_d.rdy = 1'b1;
                    acc_d.err = 1'b1;
                end else begin
                    acc_d.busy          = 1'b1;
                    acc_d.cs            = '0;
                    acc_d.cs[hit_sel]   = 1'b1;
                    acc_d.oe            = !req_write;
                    acc_d.we            = req_write ? req_be : '0;
                    acc_d.width         = banks[hit_sel].width;
                    acc_d.cnt           = banks[hit_sel].wait_n;
                end
            end
        end else if (acc_q.cnt == '0) begin
            acc_d.busy  = 1'b0;
            acc_d.cs    = '0;
            acc_d.oe    = 1'b0;
            acc_d.we    = '0;
            acc_d.width = '0;
            acc_d.rdy   = 1'b1;
        end else begin
            acc_d.cnt = acc_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign rsp_ready = acc_q.rdy;
    assign rsp_err   = acc_q.err;
    assign mem_cs    = acc_q.cs;
    assign mem_oe    = acc_q.oe;
    assign mem_we    = acc_q.we;
    assign mem_width = acc_q.width;
endmodule

// File: rtl/memctl_cs_chk.sv
module memctl_cs_chk #(
    parameter int NUM_BANKS = 8,
    parameter int MAX_WAIT  = 30
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 rsp_ready,
    input logic                 rsp_err,
    input logic [NUM_BANKS-1:0] mem_cs,
    input logic                 mem_oe,
    input logic [3:0]           mem_we,
    input logic [1:0]           mem_width
);
    logic       cs_prev_q;
    logic [7:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev_q <= 1'b0;
            run_q     <= '0;
        end else begin
            cs_prev_q <= |mem_cs;
            run_q     <= (|mem_cs) ? run_q + 8'd1 : 8'd0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (mem_cs == '0 && !rsp_ready && !mem_oe)); // R1
    AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) rsp_err |-> (mem_cs == '0 && mem_we == '0 && !mem_oe)); // R4
    AST_ERR_HAS_READY: assert property (@(posedge clk) disable iff (!rst_n) rsp_err |-> rsp_ready); // R7
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mem_cs)); // R5
    AST_READY_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n) (cs_prev_q && mem_cs == '0) |-> (rsp_ready && !rsp_err)); // R5
    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_oe && (|mem_we))); // R6
    AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) (mem_oe || (|mem_we) || mem_width != 2'd0) |-> (|mem_cs)); // R9
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (|mem_cs) |-> (run_q <= 8'(MAX_WAIT))); // R8
endmodule

bind memctl_cs memctl_cs_chk #(
    .NUM_BANKS (NUM_BANKS),
    .MAX_WAIT  (MAX_WAIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rsp_ready (rsp_ready),
    .rsp_err   (rsp_err),
    .mem_cs    (mem_cs),
    .mem_oe    (mem_oe),
    .mem_we    (mem_we),
    .mem_width (mem_width)
);

// File: tb/memctl_cs_test.sv
module memctl_cs_test;
    localparam int NB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  boot_width = 2'd2;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic        cfg_valid = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [3:0]  cfg_size = '0;
    logic [4:0]  cfg_wait = '0;
    logic [1:0]  cfg_width = '0;
    logic        cfg_wp = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_ready, rsp_err, mem_oe;
    logic [NB-1:0] mem_cs;
    logic [3:0]  mem_we;
    logic [1:0]  mem_width;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    memctl_cs uut (
        .clk(clk), .rst_n(rst_n), .boot_width(boot_width),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_valid(cfg_valid), .cfg_base(cfg_base),
        .cfg_size(cfg_size), .cfg_wait(cfg_wait), .cfg_width(cfg_width), .cfg_wp(cfg_wp),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .rsp_ready(rsp_ready), .rsp_err(rsp_err), .mem_cs(mem_cs), .mem_oe(mem_oe),
        .mem_we(mem_we), .mem_width(mem_width)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int b, input bit v, input logic [31:0] base, input int sz,
                           input int w, input int pw, input bit wp);
        cfg_sel = 3'(b); cfg_valid = v; cfg_base = base; cfg_size = 4'(sz);
        cfg_wait = 5'(w); cfg_width = 2'(pw); cfg_wp = wp;
    endtask

    task automatic cfg_write(input int b, input bit v, input logic [31:0] base, input int sz,
                             input int w, input int pw, input bit wp);
        set_cfg(b, v, base, sz, w, pw, wp);
        cfg_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // watches an access already launched; exp_bank < 0 means error response
    task automatic watch(input bit wr, input logic [3:0] be, input int exp_bank, input int exp_wait,
                         input int exp_w, input bit inject, input string tag);
        int  n = 0;
        int  k;
        bit  bad = 0;
        bit  got = 0;
        logic e = 1'b0;
        logic [NB-1:0] exp_cs;
        exp_cs = (exp_bank >= 0) ? (NB'(1) << exp_bank) : '0;
        for (k = 0; k < 40; k++) begin
            if (rsp_ready) begin got = 1; e = rsp_err; break; end
            if (mem_cs != '0) begin
                n++;
                if (mem_cs != exp_cs || mem_oe != !wr || mem_we != (wr ? be : 4'h0)
                    || mem_width != 2'(exp_w)) bad = 1;
            end
            if (inject && k == 4) begin
                req_valid = 1'b1; req_write = 1'b0; req_addr = 32'hF000_0000;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(got, {tag, " ready seen"}, got, 1);
        check(e == (exp_bank < 0), {tag, " err flag"}, e, exp_bank < 0);
        check(!bad, {tag, " strobe/width values"}, mem_cs, exp_cs);
        check(n == ((exp_bank >= 0) ? exp_wait + 1 : 0) && k == n,
              {tag, " strobe length"}, n, (exp_bank >= 0) ? exp_wait + 1 : 0);
        @(negedge clk);
        if (inject) begin
            bit extra = 0;
            for (int j = 0; j < 4; j++) begin
                if (rsp_ready || mem_cs != '0) extra = 1;
                @(negedge clk);
            end
            check(!extra, {tag, " R11 ignored request"}, extra, 0);
        end
    endtask

    task automatic launch(input bit wr, input logic [31:0] a, input logic [3:0] be);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic access(input bit wr, input logic [31:0] a, input logic [3:0] be, input int exp_bank,
                          input int exp_wait, input int exp_w, input string tag);
        launch(wr, a, be);
        watch(wr, be, exp_bank, exp_wait, exp_w, 1'b0, tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(mem_cs == '0 && !mem_oe && mem_we == '0 && !rsp_ready, "R1 outputs quiet in reset", mem_cs, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs == '0 && !rsp_ready && !rsp_err, "R1 outputs quiet after reset", mem_cs, 0);

        // R1: boot bank at base 0, wait 30, strap width 2
        access(1'b0, 32'h0000_1000, 4'hF, 0, 30, 2, "R1 boot read");
        access(1'b0, 32'h0FFF_FFFC, 4'hF, 0, 30, 2, "R1 boot top of 256MB");
        access(1'b0, 32'h1000_0000, 4'hF, -1, 0, 0, "R1 R4 miss above boot");
        access(1'b0, 32'h8000_0000, 4'hF, -1, 0, 0, "R1 R4 other banks invalid");

        // R6: writes with several byte-enable patterns on boot bank, shortened wait
        cfg_write(0, 1'b1, 32'h0, 13, 1, 0, 1'b0);
        for (int be = 1; be < 16; be += 3)
            access(1'b1, 32'h0000_0040, 4'(be), 0, 1, 0, "R6 write lanes");

        // R5 R8: wait sweep 0..31 on bank 1
        for (int w = 0; w < 32; w++) begin
            cfg_write(1, 1'b1, 32'h2000_0000, 0, w, 1, 1'b0);
            access(w[0], 32'h2000_7FFC, 4'h3, 1, (w > 30) ? 30 : w, 1, "R5 R8 wait sweep");
        end

        // R2: every size code at both block edges (codes 14,15 clamp to 13)
        for (int c = 0; c < 16; c++) begin
            int       ce;
            longint   sz;
            ce = (c > 13) ? 13 : c;
            sz = longint'(1) << (15 + ce);
            cfg_write(2, 1'b1, 32'h4000_0000 | 32'h0000_1234, c, 0, 2, 1'b0);
            access(1'b0, 32'(64'h4000_0000 + sz - 1), 4'hF, 2, 0, 2, "R2 last byte inside");
            access(1'b0, 32'(64'h4000_0000 + sz), 4'hF, -1, 0, 0, "R2 first byte outside");
        end

        // R3: overlapping banks 3 and 5
        cfg_write(5, 1'b1, 32'h9000_0000, 4, 2, 1, 1'b0);
        cfg_write(3, 1'b1, 32'h9000_0000, 4, 3, 2, 1'b0);
        access(1'b0, 32'h9000_0100, 4'hF, 3, 3, 2, "R3 lower bank wins");
        cfg_write(3, 1'b0, 32'h9000_0000, 4, 3, 2, 1'b0);
        access(1'b0, 32'h9000_0100, 4'hF, 5, 2, 1, "R3 next bank after invalidate");
        access(1'b1, 32'h9000_0100, 4'h5, 5, 2, 1, "R3 R6 write to bank 5");

        // R7: write protection
        cfg_write(4, 1'b1, 32'hA000_0000, 2, 4, 0, 1'b1);
        access(1'b1, 32'hA000_0010, 4'hF, -1, 0, 0, "R7 protected write");
        access(1'b0, 32'hA000_0010, 4'hF, 4, 4, 0, "R7 protected read");

        // R9: width codes on bank 7
        for (int pw = 0; pw < 3; pw++) begin
            cfg_write(7, 1'b1, 32'hC000_0000, 1, 0, pw, 1'b0);
            access(1'b0, 32'hC000_0004, 4'hF, 7, 0, pw, "R9 width code");
        end

        // R10: register write and request in the same cycle
        cfg_write(1, 1'b1, 32'h2000_0000, 0, 2, 0, 1'b0);
        set_cfg(1, 1'b1, 32'h2000_0000, 0, 7, 0, 1'b0);
        cfg_we = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h2000_0000; req_be = 4'hF;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        watch(1'b0, 4'hF, 1, 2, 0, 1'b0, "R10 same cycle uses old wait");
        access(1'b0, 32'h2000_0000, 4'hF, 1, 7, 0, "R10 next request uses new wait");

        // R10: same-cycle enable of a bank that is still invalid -> miss
        set_cfg(6, 1'b1, 32'hE000_0000, 0, 0, 0, 1'b0);
        cfg_we = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'hE000_0000;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        watch(1'b0, 4'hF, -1, 0, 0, 1'b0, "R10 same cycle enable misses");
        access(1'b0, 32'hE000_0000, 4'hF, 6, 0, 0, "R10 enabled bank hits after");

        // R11: request during busy access is dropped
        launch(1'b0, 32'h2000_0000, 4'hF);
        watch(1'b0, 4'hF, 1, 7, 0, 1'b1, "R11 busy access");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule